// File: doc/BRIEF.md
# Slice Wrap Interrupt and Start Controller

This block sits beside a bank of eight counter slices and gathers the one-cycle wrap strobe that each slice emits when its counter rolls over. Every wrap latches a per-slice pending flag, and at the same time it produces a one-cycle request pulse on that slice's own DMA request line. Request line n is meant to be wired to request number base + n of the DMA controller. Software masks the pending flags with an enable register. It can also assert any slice's interrupt directly through a sticky force register. The masked view and a single OR-combined interrupt line are presented to the interrupt controller.

The block also holds the run-enable vector that starts and stops the slices. The enable, force and run registers each accept three write operations: a plain write, a bitmask set and a bitmask clear. Because of this, several slices can be started in the same clock cycle without a read-modify-write, and their counters stay aligned. Pending flags are cleared by writing ones to them.

Top module: `wrap_irq_ctrl`

## Requirements
- R1: After reset, the pending flags, the masked status, the run vector, the interrupt line and all request lines are zero.
- R2: A wrap strobe on slice n in one cycle sets pending flag n from the next cycle onward. This happens whatever the enable and force bits of slice n hold.
- R3: A write to the pending register (select code 0) with operation code 0, 1 or 2 clears every flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R4: When a wrap on slice n and a clearing write to flag n land in the same cycle, the wrap wins and flag n stays set.
- R5: The masked status bit n equals (pending n AND enable n) OR force n. The interrupt line is high exactly when any masked status bit is high.
- R6: A force bit, once set, stays set until a write to the force register (select code 2) clears it. Wraps and pending-flag clears do not clear it.
- R7: For the enable (select 1), force (select 2) and run (select 3) registers, operation code 0 loads the data, code 1 ORs the data in, and code 2 clears the bits that are 1 in the data.
- R8: A set operation on the run register with several data bits raises all of those run bits in the same cycle.
- R9: Each wrap on slice n produces exactly one request pulse on line n. The pulse is one cycle long, comes in the cycle after the wrap, and no other line pulses.
- R10: Operation code 3 changes no register, whatever select and data accompany it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrap_i | input | 8 | One-cycle wrap strobe per slice |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 pending, 1 enable, 2 force, 3 run |
| wr_op_i | input | 2 | Operation: 0 write, 1 set, 2 clear, 3 none |
| wr_data_i | input | 8 | Write data, bit n belongs to slice n |
| raw_o | output | 8 | Pending wrap flags |
| status_o | output | 8 | Masked status per slice |
| run_o | output | 8 | Run enable per slice |
| irq_o | output | 1 | Combined interrupt |
| dreq_o | output | 8 | Per-slice DMA request pulses |

## Verification
The stimulus applies wraps on single slices and on groups of slices, first with every mask at zero and then with partial enable and force patterns. This separates the raw latch from the masking and shows that the force term bypasses the pending flag. Clearing writes use data with the target bit at zero, with the target bit at one, and with the bit aimed at a slice that wraps in the same cycle. These three cases tell the ignore, clear and wrap-priority paths apart. The run register is driven through load, set, clear and the unused operation code, with multi-bit data, so a per-bit or staggered start shows up as a mismatch.

// File: rtl/wic_pkg.sv
package wic_pkg;
  localparam int unsigned NUM_SLICES = 8;

  typedef enum logic [1:0] {
    SEL_RAW = 2'd0,
    SEL_ENA = 2'd1,
    SEL_FRC = 2'd2,
    SEL_RUN = 2'd3
  } wic_sel_e;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_NONE = 2'd3
  } wic_op_e;
endpackage

// File: rtl/wic_maskreg.sv
module wic_maskreg
  import wic_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic         q_en;

  // next-state: load, bitmask set, bitmask clear
  always_comb begin
    q_nxt = q_r;
    q_en  = 1'b0;
    if (hit_i) begin
      unique case (wic_op_e'(op_i))
        OP_LOAD: begin q_nxt = data_i;          q_en = 1'b1; end
        OP_SET:  begin q_nxt = q_r | data_i;    q_en = 1'b1; end
        OP_CLR:  begin q_nxt = q_r & ~data_i;   q_en = 1'b1; end
        default: begin q_nxt = q_r;             q_en = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (q_en) q_r <= q_nxt;
  end

  assign q_o = q_r;
endmodule

// File: rtl/wic_rawflags.sv
module wic_rawflags #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] wrap_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;

  // one flop per slice; the wrap term is ORed last so it wins a same-cycle clear
  for (genvar n = 0; n < W; n++) begin : g_flag
    logic f_nxt;
    logic f_en;
    always_comb begin
      f_en  = wrap_i[n] | clr_i[n];
      f_nxt = wrap_i[n] | (q_r[n] & ~clr_i[n]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_r[n] <= 1'b0;
      else if (f_en) q_r[n] <= f_nxt;
    end
  end

  assign q_o = q_r;
endmodule

// File: rtl/wic_dreq.sv
module wic_dreq #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] wrap_i,
  output logic [W-1:0] dreq_o
);
  logic [W-1:0] pulse_r;
  logic [W-1:0] pulse_nxt;
  logic         pulse_en;

  always_comb begin
    pulse_nxt = wrap_i;
    pulse_en  = (|wrap_i) | (|pulse_r);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pulse_r <= '0;
    else if (pulse_en) pulse_r <= pulse_nxt;
  end

  assign dreq_o = pulse_r;
endmodule

// File: rtl/wrap_irq_ctrl.sv
module wrap_irq_ctrl
  import wic_pkg::*;
#(
  parameter int unsigned N = NUM_SLICES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] wrap_i,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_sel_i,
  input  logic [1:0]   wr_op_i,
  input  logic [N-1:0] wr_data_i,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] status_o,
  output logic [N-1:0] run_o,
  output logic         irq_o,
  output logic [N-1:0] dreq_o
);
  localparam int unsigned NREG = 3;

  logic [N-1:0] raw_clr;
  logic [N-1:0] raw_q;
  logic [N-1:0] ena_q;
  logic [N-1:0] frc_q;
  logic [N-1:0] run_q;
  logic [N-1:0] mreg_q [NREG];
  logic         op_live;

  assign op_live = wr_en_i && (wic_op_e'(wr_op_i) != OP_NONE);

  always_comb begin
    raw_clr = '0;
    if (op_live && (wic_sel_e'(wr_sel_i) == SEL_RAW)) raw_clr = wr_data_i;
  end

  wic_rawflags #(.W(N)) u_raw (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrap_i (wrap_i),
    .clr_i  (raw_clr),
    .q_o    (raw_q)
  );

  // index k drives select code k+1: enable, force, run
  for (genvar k = 0; k < NREG; k++) begin : g_mreg
    logic hit;
    assign hit = wr_en_i && (wr_sel_i == 2'(k + 1));
    wic_maskreg #(.W(N)) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit_i  (hit),
      .op_i   (wr_op_i),
      .data_i (wr_data_i),
      .q_o    (mreg_q[k])
    );
  end

  assign ena_q = mreg_q[0];
  assign frc_q = mreg_q[1];
  assign run_q = mreg_q[2];

  wic_dreq #(.W(N)) u_dreq (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrap_i (wrap_i),
    .dreq_o (dreq_o)
  );

  always_comb begin
    status_o = (raw_q & ena_q) | frc_q;
    irq_o    = |status_o;
  end

  assign raw_o = raw_q;
  assign run_o = run_q;
endmodule

// File: rtl/wic_checker.sv
module wic_checker #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] wrap_i,
  input logic         wr_en_i,
  input logic [1:0]   wr_sel_i,
  input logic [N-1:0] raw_o,
  input logic [N-1:0] run_o,
  input logic         irq_o,
  input logic [N-1:0] dreq_o,
  input logic [N-1:0] frc_q
);
  // R1: state is cleared while reset is held
  always @(negedge clk) begin
    if (!rst_n) begin
      a_r1_reset_clear: assert (raw_o == '0 && run_o == '0 && dreq_o == '0 && !irq_o);
    end
  end

  // R2 / R4: a wrap always leaves its flag set in the next cycle
  a_r2_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_i) |=> ((raw_o & $past(wrap_i)) == $past(wrap_i)));

  // R3: flags only fall after a write aimed at the pending register
  a_r3_flags_fall_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && wr_sel_i == 2'd0) |=> ((raw_o & $past(raw_o)) == $past(raw_o)));

  // R5: any force bit drives the interrupt; nothing pending and nothing forced keeps it low
  a_r5_force_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_q != '0) |-> irq_o);
  a_r5_idle_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_o == '0 && frc_q == '0) |-> !irq_o);

  // R6: force bits hold unless the force register is written
  a_r6_force_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && wr_sel_i == 2'd2) |=> (frc_q == $past(frc_q)));

  // R9: request lines follow the previous cycle's wraps
  a_r9_dreq_follows_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dreq_o == $past(wrap_i)));
endmodule

bind wrap_irq_ctrl wic_checker #(.N(N)) u_wic_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .wrap_i   (wrap_i),
  .wr_en_i  (wr_en_i),
  .wr_sel_i (wr_sel_i),
  .raw_o    (raw_o),
  .run_o    (run_o),
  .irq_o    (irq_o),
  .dreq_o   (dreq_o),
  .frc_q    (frc_q)
);

// File: tb/test_wrap_irq_ctrl.sv
module test_wrap_irq_ctrl;
  localparam int N = 8;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] wrap_i;
  logic         wr_en_i;
  logic [1:0]   wr_sel_i;
  logic [1:0]   wr_op_i;
  logic [N-1:0] wr_data_i;
  logic [N-1:0] raw_o;
  logic [N-1:0] status_o;
  logic [N-1:0] run_o;
  logic         irq_o;
  logic [N-1:0] dreq_o;

  wrap_irq_ctrl #(.N(N)) i_wrap_irq_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrap_i    (wrap_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_op_i   (wr_op_i),
    .wr_data_i (wr_data_i),
    .raw_o     (raw_o),
    .status_o  (status_o),
    .run_o     (run_o),
    .irq_o     (irq_o),
    .dreq_o    (dreq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    logic [N-1:0] raw;
    logic [N-1:0] status;
    logic [N-1:0] run;
    logic [N-1:0] dreq;
    logic         irq;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  // reference model state
  logic [N-1:0] m_raw, m_ena, m_frc, m_run;

  task automatic compare(input exp_t e);
    n_chk++;
    if (raw_o !== e.raw || status_o !== e.status || run_o !== e.run ||
        dreq_o !== e.dreq || irq_o !== e.irq) begin
      n_fail++;
      $display("FAIL %s: raw=%h status=%h run=%h dreq=%h irq=%b expected raw=%h status=%h run=%h dreq=%h irq=%b",
               e.tag, raw_o, status_o, run_o, dreq_o, irq_o,
               e.raw, e.status, e.run, e.dreq, e.irq);
    end
  endtask

  // driver: one cycle of stimulus, then push the expected post-edge view
  task automatic step(input logic [N-1:0] wr, input logic we, input logic [1:0] sel,
                      input logic [1:0] op, input logic [N-1:0] d, input string tag);
    exp_t e;
    logic [N-1:0] clr;
    @(negedge clk);
    wrap_i = wr; wr_en_i = we; wr_sel_i = sel; wr_op_i = op; wr_data_i = d;
    clr = (we && sel == 2'd0 && op != 2'd3) ? d : '0;
    m_raw = (m_raw & ~clr) | wr;
    if (we && op != 2'd3) begin
      case (sel)
        2'd1: m_ena = (op == 2'd0) ? d : (op == 2'd1) ? (m_ena | d) : (m_ena & ~d);
        2'd2: m_frc = (op == 2'd0) ? d : (op == 2'd1) ? (m_frc | d) : (m_frc & ~d);
        2'd3: m_run = (op == 2'd0) ? d : (op == 2'd1) ? (m_run | d) : (m_run & ~d);
        default: ;
      endcase
    end
    e.raw = m_raw;
    e.status = (m_raw & m_ena) | m_frc;
    e.irq = |e.status;
    e.run = m_run;
    e.dreq = wr;
    e.tag = tag;
    @(posedge clk);
    #1;
    exp_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step('0, 1'b0, 2'd0, 2'd0, '0, tag);
  endtask

  // monitor: compare one expected item per cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) compare(exp_q.pop_front());
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    exp_t r;
    rst_n = 1'b0; wrap_i = '0; wr_en_i = 1'b0; wr_sel_i = '0; wr_op_i = '0; wr_data_i = '0;
    m_raw = '0; m_ena = '0; m_frc = '0; m_run = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    r.raw = '0; r.status = '0; r.run = '0; r.dreq = '0; r.irq = 1'b0; r.tag = "R1 reset";
    compare(r);
    rst_n = 1'b1;

    step(8'h01, 1'b0, 2'd0, 2'd0, 8'h00, "R2 wrap with masks clear, R9 pulse");
    idle("R9 pulse lasts one cycle");
    step(8'h00, 1'b1, 2'd1, 2'd0, 8'h0F, "R5 enable load unmasks flag, R7");
    step(8'h00, 1'b1, 2'd0, 2'd0, 8'hFE, "R3 zero data bit leaves flag");
    step(8'h00, 1'b1, 2'd0, 2'd2, 8'h01, "R3 one clears flag");
    step(8'h81, 1'b1, 2'd0, 2'd0, 8'h81, "R4 wrap beats same-cycle clear");
    step(8'h00, 1'b1, 2'd0, 2'd1, 8'hFF, "R3 clear all flags");
    step(8'h00, 1'b1, 2'd2, 2'd1, 8'h20, "R6 force asserts unmasked slice, R5");
    step(8'h24, 1'b0, 2'd0, 2'd0, 8'h00, "R6 wraps leave force, R9 two lines");
    step(8'h00, 1'b1, 2'd0, 2'd0, 8'hFF, "R6 raw clear leaves force");
    step(8'h00, 1'b1, 2'd2, 2'd2, 8'h20, "R6 force cleared by write");
    step(8'h00, 1'b1, 2'd1, 2'd1, 8'h30, "R7 enable set op");
    step(8'h00, 1'b1, 2'd1, 2'd2, 8'h0F, "R7 enable clear op");
    step(8'hFF, 1'b0, 2'd0, 2'd0, 8'h00, "R5 masked view of all flags, R2");
    step(8'h00, 1'b1, 2'd3, 2'd1, 8'h0F, "R8 group start in one cycle");
    step(8'h00, 1'b1, 2'd3, 2'd1, 8'hF0, "R8 second group start");
    step(8'h00, 1'b1, 2'd3, 2'd2, 8'h55, "R7 run clear op");
    step(8'h00, 1'b1, 2'd3, 2'd0, 8'h3C, "R7 run load op");
    step(8'h00, 1'b1, 2'd3, 2'd3, 8'hFF, "R10 unused op on run");
    step(8'h00, 1'b1, 2'd0, 2'd3, 8'hFF, "R10 unused op on flags");
    step(8'h00, 1'b1, 2'd2, 2'd3, 8'hFF, "R10 unused op on force");
    step(8'h40, 1'b0, 2'd0, 2'd0, 8'h00, "R9 single line pulse");
    idle("R9 pulse ends");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule